// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the effective address of indexed loads and stores in a small 8-bit controller core. It holds an 11-bit index register. The low ten bits are a general-purpose address field that software may load, read back, or step up and down as a loop counter. The eleventh bit is a space selector that software can write but never read. When the selector is 0, the address falls in an 8-bit data window starting at 0x000. When it is 1, the address falls in a 1 KiB program window starting at 0xC00.

For each access request, the block adds the unsigned 8-bit offset from the instruction to the low field and folds the sum into the selected window. One cycle later it presents the 12-bit address together with a program-space marker. Program space may only be read, so every write request aimed there is reported as blocked, and write requests into data space are reported as allowed. The memories and the instruction decoder sit outside this block.

Top module: `idx_agen`

## Requirements
- R1: A synchronous reset clears the whole index register, so the low field reads 0 and the selector points at data space, and it drops `ea_valid`, `ea_prog`, `wr_ok` and `wr_blocked`.
- R2: A pulse on `lo_we` loads `lo_wdata` into the low field at the next clock edge. `rd_idx[9:0]` shows the low field, and `rd_idx[10]` always reads 0.
- R3: A pulse on `sel_we` loads `sel_wdata` into the space selector. This write is independent of the low field, and the selector is visible only through the addresses that follow.
- R4: With the selector at 0, an access request gives `ea = (low + offset) mod 256` with `ea[11:8] = 0`. The address appears with `ea_valid = 1` in the cycle after the request.
- R5: With the selector at 1, an access request gives `ea = 0xC00 + ((low + offset) mod 1024)`.
- R6: `ea_prog` accompanies each valid address and equals the selector used for it. `ea_valid` is high only in the cycle after a request.
- R7: A write request (`acc_wr = 1`) in program space gives `wr_blocked = 1` and `wr_ok = 0`. A write request in data space gives `wr_ok = 1` and `wr_blocked = 0`. A read gives neither.
- R8: `inc` adds 1 to the low field modulo 1024 (1023 wraps to 0), and `dec` subtracts 1 modulo 1024 (0 wraps to 1023). Neither changes the selector.
- R9: `lo_we` overrides `inc` and `dec`. When `inc` and `dec` are asserted together without `lo_we`, the low field holds its value.
- R10: An access uses the register contents from before any write, increment or decrement issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_we | input | 1 | Load the low field |
| lo_wdata | input | 10 | Low field write data |
| sel_we | input | 1 | Load the space selector |
| sel_wdata | input | 1 | Space selector write data (1 = program space) |
| inc | input | 1 | Increment the low field |
| dec | input | 1 | Decrement the low field |
| rd_idx | output | 11 | Index read-back; bit 10 always reads 0 |
| acc_req | input | 1 | Indexed access request |
| acc_wr | input | 1 | Request is a write |
| offset | input | 8 | Unsigned instruction offset |
| ea | output | 12 | Registered effective address |
| ea_valid | output | 1 | `ea` holds the result of the previous cycle's request |
| ea_prog | output | 1 | Address lies in program space |
| wr_ok | output | 1 | Write request allowed (data space) |
| wr_blocked | output | 1 | Write request refused (program space) |

## Verification
The bench targets the carry out of the 8-bit data window. A design that did not truncate there would leak the carry into bit 8 and land outside data space. It also targets the carry out of bit 9 in program space, where an untruncated sum would escape the 0xC00 window. Increments past 1023 and decrements below 0 are checked because a wide counter would carry into the selector, and that would silently switch spaces. Requests issued in the same cycle as a register write must show the old value, since a forwarding path would change the address. Write requests in both spaces confirm that only program space is refused, and read-back confirms the selector never appears on `rd_idx`.

// File: rtl/idx_agen_pkg.sv
package idx_agen_pkg;

  typedef enum logic [1:0] {
    LOP_HOLD = 2'd0,
    LOP_LOAD = 2'd1,
    LOP_INC  = 2'd2,
    LOP_DEC  = 2'd3
  } lo_op_e;

  // Load wins; increment and decrement together cancel.
  function automatic lo_op_e pick_lo_op(input logic we, input logic up, input logic down);
    if (we)              return LOP_LOAD;
    else if (up && !down) return LOP_INC;
    else if (down && !up) return LOP_DEC;
    else                 return LOP_HOLD;
  endfunction

endpackage

// File: rtl/idx_reg.sv
module idx_reg
  import idx_agen_pkg::*;
#(
  parameter int LO_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  lo_op_e          op,
  input  logic [LO_W-1:0] lo_d,
  input  logic            sel_we,
  input  logic            sel_d,
  output logic [LO_W-1:0] lo_q,
  output logic            sel_q
);
  localparam logic [LO_W-1:0] ONE = LO_W'(1);

  // Low field: wraps within LO_W bits, so no carry reaches the selector.
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
    end else begin
      unique case (op)
        LOP_LOAD: lo_q <= lo_d;
        LOP_INC:  lo_q <= lo_q + ONE;
        LOP_DEC:  lo_q <= lo_q - ONE;
        default:  lo_q <= lo_q;
      endcase
    end
  end

  // Space selector: write-only from the software side.
  always_ff @(posedge clk) begin
    if (rst)         sel_q <= 1'b0;
    else if (sel_we) sel_q <= sel_d;
  end
endmodule

// File: rtl/idx_ea_calc.sv
module idx_ea_calc #(
  parameter int              LO_W      = 10,
  parameter int              OFF_W     = 8,
  parameter int              EA_W      = 12,
  parameter int              DWIN_W    = 8,
  parameter logic [EA_W-1:0] PROG_BASE = 'hC00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [LO_W-1:0]  lo,
  input  logic             sel,
  input  logic [OFF_W-1:0] off,
  output logic [EA_W-1:0]  ea_q,
  output logic             valid_q,
  output logic             prog_q
);
  logic [LO_W-1:0] sum;
  logic [EA_W-1:0] ea_data;
  logic [EA_W-1:0] ea_prog;
  logic [EA_W-1:0] ea_next;

  always_comb begin
    sum     = lo + LO_W'(off);
    ea_data = EA_W'(sum[DWIN_W-1:0]);
    ea_prog = PROG_BASE + EA_W'(sum);
    ea_next = sel ? ea_prog : ea_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_q    <= '0;
      valid_q <= 1'b0;
      prog_q  <= 1'b0;
    end else begin
      valid_q <= req;
      if (req) begin
        ea_q   <= ea_next;
        prog_q <= sel;
      end else begin
        prog_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/idx_access_guard.sv
module idx_access_guard (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic wr,
  input  logic sel,
  output logic wr_ok_q,
  output logic wr_blk_q
);
  logic is_write;
  assign is_write = req & wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ok_q  <= 1'b0;
      wr_blk_q <= 1'b0;
    end else begin
      wr_ok_q  <= is_write & ~sel;
      wr_blk_q <= is_write & sel;
    end
  end
endmodule

// File: rtl/idx_agen.sv
module idx_agen
  import idx_agen_pkg::*;
#(
  parameter int              LO_W      = 10,
  parameter int              OFF_W     = 8,
  parameter int              EA_W      = 12,
  parameter int              DWIN_W    = 8,
  parameter logic [EA_W-1:0] PROG_BASE = 'hC00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lo_we,
  input  logic [LO_W-1:0]  lo_wdata,
  input  logic             sel_we,
  input  logic             sel_wdata,
  input  logic             inc,
  input  logic             dec,
  output logic [LO_W:0]    rd_idx,
  input  logic             acc_req,
  input  logic             acc_wr,
  input  logic [OFF_W-1:0] offset,
  output logic [EA_W-1:0]  ea,
  output logic             ea_valid,
  output logic             ea_prog,
  output logic             wr_ok,
  output logic             wr_blocked
);
  localparam int IDX_W = LO_W + 1;

  lo_op_e          lo_op;
  logic [LO_W-1:0] lo_field;
  logic            space_sel;

  assign lo_op  = pick_lo_op(lo_we, inc, dec);
  assign rd_idx = IDX_W'({1'b0, lo_field});

  idx_reg #(.LO_W(LO_W)) u_reg (
    .clk    (clk),
    .rst    (rst),
    .op     (lo_op),
    .lo_d   (lo_wdata),
    .sel_we (sel_we),
    .sel_d  (sel_wdata),
    .lo_q   (lo_field),
    .sel_q  (space_sel)
  );

  idx_ea_calc #(
    .LO_W(LO_W), .OFF_W(OFF_W), .EA_W(EA_W), .DWIN_W(DWIN_W), .PROG_BASE(PROG_BASE)
  ) u_ea (
    .clk     (clk),
    .rst     (rst),
    .req     (acc_req),
    .lo      (lo_field),
    .sel     (space_sel),
    .off     (offset),
    .ea_q    (ea),
    .valid_q (ea_valid),
    .prog_q  (ea_prog)
  );

  idx_access_guard u_guard (
    .clk      (clk),
    .rst      (rst),
    .req      (acc_req),
    .wr       (acc_wr),
    .sel      (space_sel),
    .wr_ok_q  (wr_ok),
    .wr_blk_q (wr_blocked)
  );
endmodule

// File: rtl/idx_agen_chk.sv
module idx_agen_chk #(
  parameter int LO_W = 10,
  parameter int EA_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            lo_we,
  input logic            inc,
  input logic            dec,
  input logic            sel_we,
  input logic [LO_W:0]   rd_idx,
  input logic            space_sel,
  input logic [EA_W-1:0] ea,
  input logic            ea_valid,
  input logic            ea_prog,
  input logic            wr_ok,
  input logic            wr_blocked
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (rd_idx == '0) && !space_sel && !ea_valid && !wr_ok && !wr_blocked);

  a_r4_data_window: assert property (@(posedge clk) disable iff (rst)
    (ea_valid && !ea_prog) |-> (ea[EA_W-1:8] == '0));

  a_r5_prog_window: assert property (@(posedge clk) disable iff (rst)
    (ea_valid && ea_prog) |-> (ea[EA_W-1:EA_W-2] == 2'b11));

  a_r7_block_excl: assert property (@(posedge clk) disable iff (rst)
    wr_blocked |-> (!wr_ok && ea_prog && ea_valid));

  a_r7_ok_data: assert property (@(posedge clk) disable iff (rst)
    wr_ok |-> (!ea_prog && ea_valid));

  a_r8_inc_wrap: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec && !lo_we) |=> rd_idx[LO_W-1:0] == $past(rd_idx[LO_W-1:0]) + LO_W'(1));

  a_r8_dec_wrap: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc && !lo_we) |=> rd_idx[LO_W-1:0] == $past(rd_idx[LO_W-1:0]) - LO_W'(1));

  a_r8_sel_kept: assert property (@(posedge clk) disable iff (rst)
    !sel_we |=> $stable(space_sel));

  a_r9_cancel: assert property (@(posedge clk) disable iff (rst)
    (inc && dec && !lo_we) |=> $stable(rd_idx));

  a_r2_top_zero: assert property (@(posedge clk) disable iff (rst)
    rd_idx[LO_W] == 1'b0);
endmodule

bind idx_agen idx_agen_chk #(.LO_W(LO_W), .EA_W(EA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lo_we      (lo_we),
  .inc        (inc),
  .dec        (dec),
  .sel_we     (sel_we),
  .rd_idx     (rd_idx),
  .space_sel  (space_sel),
  .ea         (ea),
  .ea_valid   (ea_valid),
  .ea_prog    (ea_prog),
  .wr_ok      (wr_ok),
  .wr_blocked (wr_blocked)
);

// File: tb/idx_agen_test.sv
`timescale 1ns/1ps
module idx_agen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lo_we = 0, sel_we = 0, sel_wdata = 0, inc = 0, dec = 0;
  logic [9:0]  lo_wdata = '0;
  logic        acc_req = 0, acc_wr = 0;
  logic [7:0]  offset = '0;
  logic [10:0] rd_idx;
  logic [11:0] ea;
  logic        ea_valid, ea_prog, wr_ok, wr_blocked;

  always #10 clk = ~clk;

  idx_agen uut (
    .clk(clk), .rst(rst), .lo_we(lo_we), .lo_wdata(lo_wdata), .sel_we(sel_we),
    .sel_wdata(sel_wdata), .inc(inc), .dec(dec), .rd_idx(rd_idx), .acc_req(acc_req),
    .acc_wr(acc_wr), .offset(offset), .ea(ea), .ea_valid(ea_valid), .ea_prog(ea_prog),
    .wr_ok(wr_ok), .wr_blocked(wr_blocked)
  );

  typedef struct {
    logic [11:0] ea;
    logic        prog;
    logic        ok;
    logic        blk;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  int   m_lo   = 0;
  int   m_sel  = 0;
  bit   done   = 0;

  task automatic chk(input bit good, input string tag, input int act, input int expv);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // One cycle: drive inputs after a falling edge, queue the expected result,
  // advance to the next falling edge, then update the bench model.
  task automatic step(input bit lwe, input int ld, input bit swe, input bit sd,
                      input bit up, input bit dn, input bit req, input bit wr,
                      input int off, input string tag);
    exp_t e;
    lo_we = lwe; lo_wdata = 10'(ld); sel_we = swe; sel_wdata = sd;
    inc = up; dec = dn; acc_req = req; acc_wr = wr; offset = 8'(off);
    if (req) begin
      // R10: the request sees the model before this cycle's updates
      e.prog = (m_sel != 0);
      e.ea   = e.prog ? 12'(12'hC00 + ((m_lo + off) % 1024)) : 12'((m_lo + off) % 256);
      e.ok   = wr && !e.prog;
      e.blk  = wr && e.prog;
      e.tag  = tag;
      exp_q.push_back(e);
    end
    @(negedge clk);
    if (lwe)            m_lo = ld;
    else if (up && !dn) m_lo = (m_lo + 1) % 1024;
    else if (dn && !up) m_lo = (m_lo + 1023) % 1024;
    if (swe) m_sel = sd;
    lo_we = 0; sel_we = 0; inc = 0; dec = 0; acc_req = 0; acc_wr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    m_lo = 0; m_sel = 0;
    exp_q.delete();
  endtask

  // Monitor: pops one expected item for every valid address.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (ea_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R6 unexpected ea_valid", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(ea == e.ea, {e.tag, " ea"}, int'(ea), int'(e.ea));
          chk(ea_prog == e.prog, {"R6 ea_prog ", e.tag}, int'(ea_prog), int'(e.prog));
          chk(wr_ok == e.ok, {"R7 wr_ok ", e.tag}, int'(wr_ok), int'(e.ok));
          chk(wr_blocked == e.blk, {"R7 wr_blocked ", e.tag}, int'(wr_blocked), int'(e.blk));
        end
      end else begin
        if (wr_ok || wr_blocked) chk(0, "R7 flag without request", int'({wr_ok, wr_blocked}), 0);
      end
    end
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1: reset state
    chk(rd_idx == 11'd0, "R1 rd_idx after reset", int'(rd_idx), 0);
    chk(!ea_valid && !wr_ok && !wr_blocked, "R1 outputs idle", int'({ea_valid, wr_ok, wr_blocked}), 0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 5, "R1 data space after reset");

    // R2 / R4
    step(1, 'h0F0, 0, 0, 0, 0, 0, 0, 0, "");
    chk(rd_idx == 11'h0F0, "R2 low field load", int'(rd_idx), 'h0F0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 'h20, "R4 data truncation");
    step(0, 0, 0, 0, 0, 0, 1, 1, 'h05, "R4 data write");

    // R3 / R5 / R7
    step(0, 0, 1, 1, 0, 0, 0, 0, 0, "");
    chk(rd_idx == 11'h0F0, "R3 selector not readable", int'(rd_idx), 'h0F0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 'h20, "R5 program read");
    step(0, 0, 0, 0, 0, 0, 1, 1, 'h20, "R7 program write blocked");
    step(1, 'h3F0, 0, 0, 0, 0, 0, 0, 0, "");
    step(0, 0, 0, 0, 0, 0, 1, 0, 'h20, "R5 program wrap");
    step(0, 0, 0, 0, 0, 0, 1, 0, 'hFF, "R5 max offset");

    // R8: wraps and selector preserved
    step(1, 'h3FF, 0, 0, 0, 0, 0, 0, 0, "");
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, "");
    chk(rd_idx == 11'h000, "R8 increment wrap", int'(rd_idx), 0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 3, "R8 selector kept after inc");
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, "");
    chk(rd_idx == 11'h3FF, "R8 decrement wrap", int'(rd_idx), 'h3FF);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, "R8 selector kept after dec");

    // R9: priority
    step(1, 'h055, 0, 0, 1, 0, 0, 0, 0, "");
    chk(rd_idx == 11'h055, "R9 load beats inc", int'(rd_idx), 'h055);
    step(0, 0, 0, 0, 1, 1, 0, 0, 0, "");
    chk(rd_idx == 11'h055, "R9 inc and dec cancel", int'(rd_idx), 'h055);

    // R10: same-cycle updates are not forwarded
    step(1, 'h123, 0, 0, 0, 0, 1, 0, 1, "R10 old low field");
    step(0, 0, 1, 0, 0, 0, 1, 1, 1, "R10 old selector");
    step(0, 0, 0, 0, 1, 0, 1, 1, 1, "R10 data write with inc");
    chk(rd_idx == 11'h124, "R10 inc after access", int'(rd_idx), 'h124);

    // back-to-back requests, then reset from program space
    step(0, 0, 1, 1, 0, 0, 1, 0, 'h80, "R6 back to back 1");
    step(0, 0, 0, 0, 0, 0, 1, 0, 'h80, "R6 back to back 2");
    idle(2);
    do_reset();
    chk(rd_idx == 11'd0, "R1 rd_idx after second reset", int'(rd_idx), 0);
    step(0, 0, 0, 0, 0, 0, 1, 1, 'h40, "R1 selector cleared by reset");
    idle(2);

    done = 1;
    chk(exp_q.size() == 0, "R6 missing results", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule